// File: doc/BRIEF.md
# Dual-Mode FSK Character Output Port

This block sits behind a 1200-baud FSK demodulator and turns its recovered bit stream into something a microcontroller can read. It oversamples the demodulated line sixteen times per bit, finds each asynchronous character (a low start bit, eight data bits with the least significant bit first, a high stop bit), and hands the result out in one of two ways chosen by a mode input.

In streaming mode (mode input low) every accepted bit appears on the data output together with a regenerated bit clock whose rising edge falls in the middle of each bit's output window, and an active-low ready pulse one bit period long marks every character whose stop bit was valid. In buffered mode (mode input high) each good character is latched into a one-byte buffer, the ready line drops, and the host shifts the byte out least significant bit first with its own read clock at any rate it likes. The clock pin is then an input, so the block's drive enable for it is released.

An output enable and a power-down input force all four host-facing lines high and clear the internal state. A carrier-valid flag from the analog side drives an active-low carrier-detect output that is held for a fixed time after the carrier drops, and the data output stays high whenever carrier-detect is inactive.

Top module: `fsk_byte_port`

## Requirements
- R1: While `en_i` is 0 or `pdn_i` is 1, `dout_o`, `bclk_o`, `dr_no` and `cd_no` are 1 and `ovr_o` is 0; all receive, buffer and carrier state is cleared, so ready stays 1 after the gate is lifted.
- R2: A character is a 0 start bit, eight data bits with bit 0 first, and a 1 stop bit; a falling edge is accepted as a start only if the line is still 0 at mid-bit (8 sample ticks later), so a low glitch shorter than half a bit produces no output.
- R3: A character whose stop bit samples as 0 produces no ready pulse in mode 0 and loads nothing in mode 1.
- R4: In mode 0, each accepted bit (start, eight data, stop) is put on `dout_o` while `bclk_o` goes low; `bclk_o` returns high 8 sample ticks later (32 system clocks at the default divider), so rising edges of `bclk_o` capture the ten frame bits in order.
- R5: In mode 0, a character with a valid stop bit drives `dr_no` low for one bit period (16 sample ticks, 64 system clocks by default), starting at the stop-bit sample.
- R6: In mode 1, a valid character loads the buffer, drives `dr_no` low and shows bit 0 on `dout_o`; each rising edge of `rclk_i` advances to the next bit, and after the eighth edge `dr_no` returns to 1 and `dout_o` to 1.
- R7: In mode 1, a character that completes while the previous byte is still held (unread or partly read) replaces it, restarts the read at bit 0 and sets `ovr_o`, which stays 1 until the gate of R1 is applied.
- R8: `cd_no` goes 0 one clock after `carrier_i` rises and returns to 1 only after `carrier_i` has been 0 for `CD_HOLD_TICKS` sample ticks (160 ticks, 640 clocks by default).
- R9: `dout_o` is 1 whenever `cd_no` is 1, whatever data is pending.
- R10: Characters sent at bit periods 1.5 % off nominal in either direction are received correctly.
- R11: In mode 1 `bclk_oe_o` is 0 and `bclk_o` is 1; in mode 0 `bclk_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: streaming with bit clock, 1: buffered byte read by external clock |
| en_i | input | 1 | Output enable, active high |
| pdn_i | input | 1 | Power-down, active high |
| carrier_i | input | 1 | Carrier-valid flag from the demodulator |
| bit_i | input | 1 | Demodulated serial bit |
| rclk_i | input | 1 | External read clock (mode 1) |
| dout_o | output | 1 | Serial data to host |
| bclk_o | output | 1 | Regenerated bit clock (mode 0) |
| bclk_oe_o | output | 1 | Drive enable for the clock pin |
| dr_no | output | 1 | Data ready, active low |
| cd_no | output | 1 | Carrier detect, active low |
| ovr_o | output | 1 | Sticky buffer overrun flag (mode 1) |

## Verification
The two functions that meet in one cycle are a buffer load from a freshly completed character and a read-clock advance of the byte still being shifted out. The bench provokes this by reading only three bits of one character and then sending a second one while the first is still held; the load must win, so the overrun flag must rise, the read pointer must restart and all eight bits read afterwards must be those of the second character. Streaming mode has a similar meeting point where the ready pulse of one character overlaps the start of the next, judged through exact pulse widths over back-to-back random characters.

// File: rtl/fsk_byte_pkg.sv
package fsk_byte_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  typedef struct packed {
    logic smp;      // a frame bit was accepted this cycle
    logic val;      // its value
    logic done;     // stop bit sampled
    logic stop_ok;  // stop bit was 1
  } rx_evt_t;
endpackage

// File: rtl/fsk_char_rx.sv
module fsk_char_rx
  import fsk_byte_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int OSR      = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_i,
  output logic              tick_o,
  output rx_evt_t           evt_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PW = $clog2(OSR);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TW-1:0] T_LAST   = TW'(TICK_DIV - 1);
  localparam logic [PW-1:0] PH_MID   = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] PH_END   = PW'(OSR - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

  logic            s1_q, s2_q, prev_q;
  logic [TW-1:0]   tcnt_q;
  logic [PW-1:0]   ph_q;
  logic [IW-1:0]   idx_q;
  rx_state_e       st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1; prev_q <= 1'b1;
      tcnt_q <= '0; tick_o <= 1'b0;
      ph_q <= '0; idx_q <= '0; st_q <= RX_IDLE;
      evt_o <= '0; byte_o <= '0;
    end else if (clr_i) begin
      s1_q <= 1'b1; s2_q <= 1'b1; prev_q <= 1'b1;
      tcnt_q <= '0; tick_o <= 1'b0;
      ph_q <= '0; idx_q <= '0; st_q <= RX_IDLE;
      evt_o <= '0; byte_o <= '0;
    end else begin
      s1_q   <= bit_i;
      s2_q   <= s1_q;
      tick_o <= (tcnt_q == T_LAST);
      tcnt_q <= (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
      evt_o  <= '0;
      if (tick_o) begin
        prev_q <= s2_q;
        unique case (st_q)
          RX_IDLE: if (prev_q && !s2_q) begin
            st_q <= RX_START;
            ph_q <= '0;
          end
          RX_START: if (ph_q == PH_MID) begin
            ph_q  <= '0;
            idx_q <= '0;
            if (!s2_q) begin
              st_q      <= RX_DATA;
              evt_o.smp <= 1'b1;
              evt_o.val <= 1'b0;
            end else begin
              st_q <= RX_IDLE;  // glitch, not a start
            end
          end else ph_q <= ph_q + 1'b1;
          RX_DATA: if (ph_q == PH_END) begin
            ph_q      <= '0;
            byte_o    <= {s2_q, byte_o[DATA_W-1:1]};
            evt_o.smp <= 1'b1;
            evt_o.val <= s2_q;
            if (idx_q == IDX_LAST) st_q <= RX_STOP;
            else                   idx_q <= idx_q + 1'b1;
          end else ph_q <= ph_q + 1'b1;
          RX_STOP: if (ph_q == PH_END) begin
            ph_q          <= '0;
            st_q          <= RX_IDLE;
            evt_o.smp     <= 1'b1;
            evt_o.val     <= s2_q;
            evt_o.done    <= 1'b1;
            evt_o.stop_ok <= s2_q;
          end else ph_q <= ph_q + 1'b1;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  a_r2_done_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.done |-> $past(st_q == RX_STOP));

  a_r2_smp_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.smp |-> $past(tick_o));
endmodule

// File: rtl/fsk_stream_out.sv
module fsk_stream_out
  import fsk_byte_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    tick_i,
  input  rx_evt_t evt_i,
  output logic    sdout_o,
  output logic    sclk_o,
  output logic    sdr_no
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] HALF_LAST = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] FULL_LAST = PW'(OSR - 1);

  logic          tick_d_q;  // aligns tick phase with event cycles
  logic [PW-1:0] hcnt_q, dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_d_q <= 1'b0; hcnt_q <= '0; dcnt_q <= '0;
      sdout_o <= 1'b1; sclk_o <= 1'b1; sdr_no <= 1'b1;
    end else if (clr_i) begin
      tick_d_q <= 1'b0; hcnt_q <= '0; dcnt_q <= '0;
      sdout_o <= 1'b1; sclk_o <= 1'b1; sdr_no <= 1'b1;
    end else begin
      tick_d_q <= tick_i;
      if (evt_i.smp) begin
        sdout_o <= evt_i.val;
        sclk_o  <= 1'b0;
        hcnt_q  <= '0;
      end else if (tick_d_q && !sclk_o) begin
        if (hcnt_q == HALF_LAST) sclk_o <= 1'b1;
        else                     hcnt_q <= hcnt_q + 1'b1;
      end
      if (evt_i.done && evt_i.stop_ok) begin
        sdr_no <= 1'b0;
        dcnt_q <= '0;
      end else if (tick_d_q && !sdr_no) begin
        if (dcnt_q == FULL_LAST) sdr_no <= 1'b1;
        else                     dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  a_r5_dr_after_valid_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdr_no) |-> $past(evt_i.done && evt_i.stop_ok));

  a_r4_clk_fall_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $past(evt_i.smp));
endmodule

// File: rtl/fsk_byte_buf.sv
module fsk_byte_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              mode_i,
  input  logic              done_i,
  input  logic              stop_ok_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rclk_i,
  output logic              bdout_o,
  output logic              bdr_o,
  output logic              ovr_o
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] PTR_LAST = IW'(DATA_W - 1);

  logic              r1_q, r2_q, r3_q;
  logic [DATA_W-1:0] buf_q;
  logic [IW-1:0]     ptr_q;
  logic              clr_eff, load, rd_rise;

  assign clr_eff = clr_i | ~mode_i;
  assign load    = done_i & stop_ok_i;
  assign rd_rise = r2_q & ~r3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= 1'b0; r2_q <= 1'b0; r3_q <= 1'b0;
      buf_q <= '0; ptr_q <= '0; bdr_o <= 1'b0; ovr_o <= 1'b0;
    end else if (clr_eff) begin
      r1_q <= 1'b0; r2_q <= 1'b0; r3_q <= 1'b0;
      buf_q <= '0; ptr_q <= '0; bdr_o <= 1'b0; ovr_o <= 1'b0;
    end else begin
      r1_q <= rclk_i;
      r2_q <= r1_q;
      r3_q <= r2_q;
      if (load) begin
        // load has priority over a read edge in the same cycle
        buf_q <= byte_i;
        ptr_q <= '0;
        bdr_o <= 1'b1;
        ovr_o <= ovr_o | bdr_o;
      end else if (bdr_o && rd_rise) begin
        if (ptr_q == PTR_LAST) begin
          bdr_o <= 1'b0;
          ptr_q <= '0;
        end else ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign bdout_o = bdr_o ? buf_q[ptr_q] : 1'b1;

  a_r6_dr_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bdr_o && rd_rise && ptr_q == PTR_LAST && !load && !clr_eff) |=> !bdr_o);

  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_eff) |=> ovr_o);
endmodule

// File: rtl/fsk_carrier_hold.sv
module fsk_carrier_hold #(
  parameter int CD_HOLD_TICKS = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic carrier_i,
  output logic act_o
);
  localparam int CW = $clog2(CD_HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD = CW'(CD_HOLD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; act_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; act_o <= 1'b0;
    end else if (carrier_i) begin
      cnt_q <= HOLD; act_o <= 1'b1;
    end else if (act_o) begin
      if (cnt_q == '0) act_o <= 1'b0;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r8_cd_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carrier_i && !clr_i) |=> act_o);
endmodule

// File: rtl/fsk_byte_port.sv
module fsk_byte_port
  import fsk_byte_pkg::*;
#(
  parameter int TICK_DIV      = 4,
  parameter int OSR           = 16,
  parameter int DATA_W        = 8,
  parameter int CD_HOLD_TICKS = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic en_i,
  input  logic pdn_i,
  input  logic carrier_i,
  input  logic bit_i,
  input  logic rclk_i,
  output logic dout_o,
  output logic bclk_o,
  output logic bclk_oe_o,
  output logic dr_no,
  output logic cd_no,
  output logic ovr_o
);
  logic              gate, tick;
  rx_evt_t           evt;
  logic [DATA_W-1:0] rx_byte;
  logic              sdout, sclk, sdr_n;
  logic              bdout, bdr, bovr;
  logic              cd_act;

  assign gate = ~en_i | pdn_i;

  fsk_char_rx #(.TICK_DIV(TICK_DIV), .OSR(OSR), .DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .clr_i(gate), .bit_i,
    .tick_o(tick), .evt_o(evt), .byte_o(rx_byte)
  );

  fsk_stream_out #(.OSR(OSR)) u_stream (
    .clk_i, .rst_ni, .clr_i(gate), .tick_i(tick), .evt_i(evt),
    .sdout_o(sdout), .sclk_o(sclk), .sdr_no(sdr_n)
  );

  fsk_byte_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(gate), .mode_i,
    .done_i(evt.done), .stop_ok_i(evt.stop_ok), .byte_i(rx_byte), .rclk_i,
    .bdout_o(bdout), .bdr_o(bdr), .ovr_o(bovr)
  );

  fsk_carrier_hold #(.CD_HOLD_TICKS(CD_HOLD_TICKS)) u_cd (
    .clk_i, .rst_ni, .clr_i(gate), .tick_i(tick), .carrier_i, .act_o(cd_act)
  );

  always_comb begin
    if (gate || !cd_act) dout_o = 1'b1;
    else if (mode_i)     dout_o = bdout;
    else                 dout_o = sdout;
  end

  assign bclk_o    = (gate || mode_i) ? 1'b1 : sclk;
  assign bclk_oe_o = ~mode_i;
  assign dr_no     = gate ? 1'b1 : (mode_i ? ~bdr : sdr_n);
  assign cd_no     = gate ? 1'b1 : ~cd_act;
  assign ovr_o     = gate ? 1'b0 : bovr;

  a_r1_gate_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate |=> (!bdr && !bovr && !cd_act && sdr_n));

  a_r9_dout_high_no_cd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_no |-> dout_o);
endmodule

// File: tb/sim_fsk_byte_port.sv
`timescale 1ns/1ps
module sim_fsk_byte_port;
  localparam int TICK_DIV = 4;
  localparam int BIT_CYC  = 16 * TICK_DIV;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_i = 1'b0, en_i = 1'b1, pdn_i = 1'b0, carrier_i = 1'b0;
  logic bit_i = 1'b1, rclk_i = 1'b0;
  logic dout_o, bclk_o, bclk_oe_o, dr_no, cd_no, ovr_o;

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  fsk_byte_port u0 (
    .clk_i(clk), .rst_ni, .mode_i, .en_i, .pdn_i, .carrier_i, .bit_i, .rclk_i,
    .dout_o, .bclk_o, .bclk_oe_o, .dr_no, .cd_no, .ovr_o
  );

  // stream capture and pulse-width monitors
  logic cap [0:511];
  int cap_n = 0;
  always @(posedge bclk_o) if (cap_n < 512) begin cap[cap_n] = dout_o; cap_n++; end

  int dr_low = 0, dr_pulses = 0, dr_last = 0;
  int ck_low = 0, ck_last = 0;
  always @(negedge clk) begin
    if (!dr_no) dr_low++;
    else if (dr_low != 0) begin dr_pulses++; dr_last = dr_low; dr_low = 0; end
    if (!bclk_o) ck_low++;
    else if (ck_low != 0) begin ck_last = ck_low; ck_low = 0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop, input int blen);
    bit_i = 1'b0; wait_n(blen);
    for (int i = 0; i < 8; i++) begin bit_i = b[i]; wait_n(blen); end
    bit_i = stop; wait_n(blen);
    bit_i = 1'b1; wait_n(2 * blen);
  endtask

  task automatic read_bits(input int n, output logic [7:0] v);
    v = 8'hFF;
    for (int i = 0; i < n; i++) begin
      v[i] = dout_o;
      rclk_i = 1'b1; wait_n(20);
      rclk_i = 1'b0; wait_n(20);
    end
  endtask

  function automatic logic [9:0] frame(input logic [7:0] b, input logic stop);
    return {stop, b, 1'b0};
  endfunction

  task automatic chk_stream(input string tag, input int n0, input logic [9:0] exp);
    logic [9:0] got;
    chk({tag, " bit count"}, cap_n - n0, 10);
    for (int i = 0; i < 10; i++) got[i] = (n0 + i < 512) ? cap[n0 + i] : 1'bx;
    chk({tag, " frame"}, {22'd0, got}, {22'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, v;
    int n0, p0, blen;
    void'($urandom(32'd1234));
    wait_n(4);
    rst_ni = 1'b1;
    wait_n(4);

    // reset state, no carrier
    chk("R9 reset dout", dout_o, 1);
    chk("R8 reset cd", cd_no, 1);
    chk("R5 reset dr", dr_no, 1);
    chk("R11 reset oe mode0", bclk_oe_o, 1);
    chk("R7 reset ovr", ovr_o, 0);

    carrier_i = 1'b1;
    wait_n(2);
    chk("R8 cd on", cd_no, 0);

    // mode 0 directed
    n0 = cap_n; p0 = dr_pulses;
    send_char(8'hA5, 1'b1, BIT_CYC);
    chk_stream("R4 R2 A5", n0, frame(8'hA5, 1'b1));
    chk("R5 dr pulse count", dr_pulses - p0, 1);
    chk("R5 dr width", dr_last, BIT_CYC);
    chk("R4 bclk low width", ck_last, BIT_CYC / 2);

    // mode 0 random, baud within tolerance
    for (int k = 0; k < 8; k++) begin
      b = 8'($urandom);
      blen = BIT_CYC - 1 + int'($urandom % 3);
      n0 = cap_n; p0 = dr_pulses;
      send_char(b, 1'b1, blen);
      chk_stream("R10 random", n0, frame(b, 1'b1));
      chk("R5 random dr pulse", dr_pulses - p0, 1);
    end

    // framing error: stop sampled 0
    n0 = cap_n; p0 = dr_pulses;
    send_char(8'h3C, 1'b0, BIT_CYC);
    chk_stream("R3 bad stop stream", n0, frame(8'h3C, 1'b0));
    chk("R3 no dr on bad stop", dr_pulses - p0, 0);
    bit_i = 1'b1; wait_n(2 * BIT_CYC);

    // short low glitch
    n0 = cap_n;
    bit_i = 1'b0; wait_n(12);
    bit_i = 1'b1; wait_n(3 * BIT_CYC);
    chk("R2 glitch ignored", cap_n - n0, 0);

    // mode 1
    mode_i = 1'b1;
    wait_n(4);
    chk("R11 oe off mode1", bclk_oe_o, 0);
    chk("R11 bclk high mode1", bclk_o, 1);
    chk("R6 dr idle mode1", dr_no, 1);

    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom);
      send_char(b, 1'b1, BIT_CYC - 1 + int'($urandom % 3));
      chk("R6 dr low after char", dr_no, 0);
      read_bits(8, v);
      chk("R6 read byte", v, b);
      chk("R6 dr released", dr_no, 1);
      chk("R6 dout idle after read", dout_o, 1);
    end

    send_char(8'h81, 1'b0, BIT_CYC);
    chk("R3 bad stop not loaded", dr_no, 1);

    // overrun: partial read, then next character
    chk("R7 ovr clear", ovr_o, 0);
    send_char(8'h5A, 1'b1, BIT_CYC);
    read_bits(3, v);
    chk("R7 partial bits", v[2:0], 3'b010);
    send_char(8'hC3, 1'b1, BIT_CYC);
    chk("R7 ovr set", ovr_o, 1);
    read_bits(8, v);
    chk("R7 new byte wins", v, 8'hC3);
    chk("R7 ovr sticky", ovr_o, 1);

    // carrier release forces dout high
    send_char(8'h02, 1'b1, BIT_CYC);
    chk("R6 b0 shown", dout_o, 0);
    carrier_i = 1'b0;
    wait_n(300);
    chk("R8 cd held", cd_no, 0);
    chk("R9 dout while cd held", dout_o, 0);
    wait_n(400);
    chk("R8 cd released", cd_no, 1);
    chk("R9 dout forced high", dout_o, 1);
    chk("R9 byte still held", dr_no, 0);

    // gating
    en_i = 1'b0;
    wait_n(3);
    chk("R1 en low outputs", {dout_o, bclk_o, dr_no, cd_no}, 4'hF);
    chk("R1 en low ovr", ovr_o, 0);
    en_i = 1'b1;
    wait_n(3);
    chk("R1 state cleared", dr_no, 1);
    mode_i = 1'b0;
    carrier_i = 1'b1;
    wait_n(3);
    chk("R8 cd on again", cd_no, 0);
    pdn_i = 1'b1;
    wait_n(3);
    chk("R1 pdn outputs", {dout_o, bclk_o, dr_no, cd_no}, 4'hF);
    pdn_i = 1'b0;
    wait_n(3);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule